// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 8 bits. The host offers one single-word request at a time over a valid/ready handshake, carrying a 17-bit address, a write flag and 8 bits of write data. The controller turns each request into active-low chip enable, write enable and output enable strobes together with the address. It also drives an 8-bit data-out bus paired with a drive enable for the shared I/O pins, and samples the pins' incoming value for reads.

Every timing minimum of the memory is a nanosecond parameter. Each is rounded up to whole clock cycles against the clock period parameter. A read holds its strobes for the longest of the access-time, output-enable-to-data and read-cycle counts. A write holds its strobes for the longest of the write-pulse, address-to-end, data-setup and write-cycle counts. A write ends when write enable and chip enable rise on the same edge. After a read, a turnaround gap lets the memory release the bus before the controller may drive it again.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: An accepted read (`req_write`=0) drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with `mem_addr` equal to the request address, starting at the accepting clock edge and lasting exactly RD_CYC cycles (3 with default parameters). `mem_dq_oe` stays 0 throughout.
- R3: On the edge that closes the read count, `mem_dq_in` is captured into `rsp_data`, and `rsp_valid` is 1 for exactly one cycle, RD_CYC cycles after the accepting edge.
- R4: An accepted write (`req_write`=1) drives `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1, with `mem_dq_out` equal to the write data and `mem_addr` equal to the request address, for exactly WR_CYC cycles (3 with default parameters).
- R5: A write ends with `mem_we_n` and `mem_ce_n` rising on the same edge. Address and data stay stable while `mem_we_n` is 0, and `mem_dq_oe` drops on that same edge.
- R6: After a read releases its strobes, `req_ready` stays 0 for TA_CYC further cycles (2 with default parameters). `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it rises only after `mem_oe_n` has been high for at least TA_CYC cycles.
- R7: `req_ready` is 0 from the accepting edge until the operation and any turnaround gap end. A request presented while `req_ready` is 0 has no effect on the strobes or the memory.
- R8: Each cycle count is the ceiling of its nanosecond minimum divided by CLK_NS, with a floor of 1. With CLK_NS=4, 10 ns maps to 3 cycles and 5 ns maps to 2 cycles.
- R9: `rsp_valid` pulses only after a read and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 8 | Captured read data |
| mem_addr | output | 17 | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven onto the shared I/O |
| mem_dq_oe | output | 1 | Drive enable for the shared I/O |
| mem_dq_in | input | 8 | Value seen on the shared I/O |

## Verification
Taking the accepting edge as cycle 0, the read strobes are visible after edges 0 to 2. The captured data and `rsp_valid` appear after edge 3, and `req_ready` returns after edge 5. A write's strobes and data are visible after edges 0 to 2, and everything is released, with `req_ready` high, after edge 3. The bench drives and samples on the falling edge and counts falling edges from acceptance, checking each output at the count where it is due. Random traffic is mixed with directed cases: extreme addresses, a write right after a read, and requests presented while busy.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_NS  = 4,
  parameter int T_AA    = 10,
  parameter int T_DOE   = 5,
  parameter int T_RC    = 10,
  parameter int T_WC    = 10,
  parameter int T_PWE   = 7,
  parameter int T_AW    = 8,
  parameter int T_SCE   = 8,
  parameter int T_SD    = 5,
  parameter int T_HZOE  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = max2(to_cyc(T_AA), max2(to_cyc(T_DOE), to_cyc(T_RC)));
  localparam int WR_CYC = max2(max2(to_cyc(T_PWE), to_cyc(T_AW)),
                               max2(max2(to_cyc(T_SD), to_cyc(T_WC)), to_cyc(T_SCE)));
  localparam int TA_CYC = to_cyc(T_HZOE);
  localparam int MAXC   = max2(RD_CYC, max2(WR_CYC, TA_CYC));
  localparam int CW     = $clog2(MAXC + 2);

  typedef enum logic [1:0] {IDLE, RD, WR, TURN} state_t;
  state_t        state;
  logic [CW-1:0] cnt;

  assign req_ready = (state == IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      cnt        <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          cnt      <= '0;
          if (req_write) begin
            mem_we_n   <= 1'b0;
            mem_dq_oe  <= 1'b1;
            mem_dq_out <= req_wdata;
            state      <= WR;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= RD;
          end
        end
        RD: if (cnt == CW'(RD_CYC - 1)) begin
          rsp_data  <= mem_dq_in;
          rsp_valid <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          cnt       <= '0;
          state     <= TURN;
        end else cnt <= cnt + 1'b1;
        WR: if (cnt == CW'(WR_CYC - 1)) begin
          mem_we_n  <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          cnt       <= '0;
          state     <= IDLE;
        end else cnt <= cnt + 1'b1;
        TURN: if (cnt == CW'(TA_CYC - 1)) state <= IDLE;
              else cnt <= cnt + 1'b1;
        default: state <= IDLE;
      endcase
    end
  end

  logic [CW-1:0] we_run, oe_hi;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_hi  <= CW'(TA_CYC);
    end else begin
      we_run <= mem_we_n ? '0 : ((we_run == CW'(MAXC + 1)) ? we_run : we_run + 1'b1);
      oe_hi  <= !mem_oe_n ? '0 : ((oe_hi == CW'(TA_CYC)) ? oe_hi : oe_hi + 1'b1);
    end
  end

  assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= CW'(WR_CYC)));
  assert_joint_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_ce_n && !mem_dq_oe));
  assert_stable_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi >= CW'(TA_CYC)));
  assert_single_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));
  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;
  localparam int CLK_NS = 4;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  // R8: expected counts from the nanosecond minimums
  localparam int E_RD = mx(cyc(10), mx(cyc(5), cyc(10)));
  localparam int E_WR = mx(mx(cyc(7), cyc(8)), mx(cyc(5), cyc(10)));
  localparam int E_TA = cyc(5);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_data, mem_dq_out;
  logic [7:0] mem_dq_in = '0;
  logic [16:0] mem_addr;

  sram_strobe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] sram [int];
  logic [7:0] ref_m [int];

  function automatic logic [7:0] initv(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
  endfunction

  // memory model, updated away from the active edge
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) sram[int'(mem_addr)] = mem_dq_out;
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : initv(mem_addr);
    else mem_dq_in = 8'h00;
  end

  function automatic logic [7:0] exp_rd(input logic [16:0] a);
    return ref_m.exists(int'(a)) ? ref_m[int'(a)] : initv(a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit w, input logic [16:0] a, input logic [7:0] d, input bit noise);
    logic [7:0] e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    e = exp_rd(a);
    if (w) ref_m[int'(a)] = d;
    for (int n = 1; n <= (w ? E_WR + 1 : E_RD + E_TA + 1); n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (noise) begin
          req_valid = 1; req_write = !w; req_addr = ~a; req_wdata = ~d;
        end else req_valid = 0;
      end
      if (w) begin
        if (n <= E_WR) begin
          chk(!mem_ce_n && !mem_we_n && mem_oe_n, "R4 strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b001);
          chk(mem_dq_oe && mem_dq_out == d && mem_addr == a, "R4/R5 data+addr", mem_dq_out, d);
          chk(!req_ready, "R7 busy", req_ready, 0);
        end else begin
          chk(mem_we_n && mem_ce_n && !mem_dq_oe, "R5 end", {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b110);
          chk(req_ready, "R7 ready back", req_ready, 1);
        end
        chk(!rsp_valid, "R9 no rsp on write", rsp_valid, 0);
      end else begin
        if (n <= E_RD) begin
          chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R2 strobes",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
          chk(mem_addr == a, "R2 addr", mem_addr, a);
          chk(!rsp_valid, "R3 early rsp", rsp_valid, 0);
        end else if (n == E_RD + 1) begin
          chk(rsp_valid && rsp_data == e, "R3 data", rsp_data, e);
          chk(mem_ce_n && mem_oe_n, "R2 release", {mem_ce_n, mem_oe_n}, 2'b11);
        end else chk(!rsp_valid, "R3 single pulse", rsp_valid, 0);
        if (n <= E_RD + E_TA) chk(!req_ready, "R6/R7 turnaround busy", req_ready, 0);
        else chk(req_ready, "R6 ready after gap", req_ready, 1);
        if (n > E_RD) chk(!mem_dq_oe, "R6 no drive in gap", mem_dq_oe, 0);
      end
      if (noise && n >= 1) chk(w ? 1'b1 : mem_we_n, "R7 ignored request", mem_we_n, 1);
      if (noise && n == (w ? E_WR : E_RD + E_TA)) req_valid = 0;
    end
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1 reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !rsp_valid, "R1 after reset", req_ready, 1);
    chk(E_RD == 3 && E_TA == 2 && E_WR == 3, "R8 rounding", E_RD, 3);
    op(0, 17'h00000, 8'h00, 0);
    op(1, 17'h1FFFF, 8'hA5, 0);
    op(0, 17'h1FFFF, 8'h00, 0);
    op(1, 17'h00000, 8'hFF, 0);
    op(0, 17'h00000, 8'h00, 0);
    op(0, 17'h0ABCD, 8'h00, 1);
    op(1, 17'h0ABCD, 8'h3C, 0);
    op(0, 17'h0ABCD, 8'h00, 0);
    op(1, 17'h00001, 8'h11, 1);
    op(0, 17'h00001, 8'h00, 0);
    op(0, 17'h1E000, 8'h00, 0);
    op(1, 17'h1E000, 8'h77, 0);
    for (int i = 0; i < 400; i++) begin
      logic [16:0] a;
      a = (($urandom % 2) == 0) ? 17'($urandom % 16) : 17'($urandom);
      op(1'($urandom), a, 8'($urandom), (($urandom % 8) == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule